// File: doc/BRIEF.md
# PoE Port Power-Up Sequencer

This block steps one power-sourcing port from rest to delivered power. Once enabled it probes the attached load at four stepped voltage levels. It then judges the measured signature resistance and classifies the load with one or two class events, depending on the operating mode. After that it closes the port switch under a reduced inrush current limit for a fixed start-up window, and it then holds the port powered. It runs from the 8 MHz system clock. The analog probe, class and measurement circuits are outside the block. They appear only as digital values and a one-cycle completion strobe.

When legacy acceptance is switched on, a load that fails the resistance window but shows a large enough capacitive signature is powered directly, without classification. A failed attempt parks the port for a programmable number of clock ticks before it probes again. Disabling the port or raising any protection fault turns the switch off on the next clock.

Top module: `poe_port_seq`

## Requirements
- R1: While reset is asserted, and just after it, status is 0 (idle), gate_en is 0, ilim_sel is 0 and every request is low; class_out is 0.
- R2: If idle and enabled with no fault, the next cycle shows status 1 (detecting) with probe_req high and probe_lvl 0. Each meas_valid advances probe_lvl by one, through 0, 1, 2 and 3. A restarted detection begins again at level 0.
- R3: On meas_valid at probe level 3, a meas_res from RES_LO to RES_HI inclusive (default 190 to 265, in 100 Ω units, so 19 kΩ to 26.5 kΩ) passes. A pass moves the port to classification (status 2). A value of 189 or 266 fails.
- R4: Classification is entered only from a passing detection. The mode is sampled when detection starts. In single-event mode (at_mode 0), one class event (class_req) leads to start-up. In dual-event mode, a class event, then a mark event (mark_req), then a second class event lead to start-up. At most one of probe_req, class_req and mark_req is high at a time.
- R5: class_out takes meas_class at the completion of each class event. It is cleared to 0 when a new detection starts, and it is held in every other case, including after the port is disabled.
- R6: Start-up shows status 3 with gate_en 1 and ilim_sel 1 (inrush limit) for INRUSH_TICKS cycles. The port then shows status 4 (powered) with gate_en 1 and ilim_sel 2 (single-event mode) or 3 (dual-event mode).
- R7: If the resistance fails, legacy_en is 1 and meas_cap is at least CAP_MIN (default 100), the port goes straight to start-up and class_out stays 0. With meas_cap below CAP_MIN, or with legacy_en 0, the attempt fails.
- R8: After a failed detection, status reads 0 for backoff_ticks+2 cycles, and detection then starts again.
- R9: Any set bit of fault_in gives status 5 (fault), gate_en 0, ilim_sel 0 and no requests on the next cycle, and this holds while the fault lasts. The first cycle after the fault clears shows idle. Faults take priority over everything else.
- R10: With port_en low and no fault, the next cycle shows idle with gate_en 0, and the port stays idle while port_en stays low.
- R11: A meas_valid that arrives during back-off, start-up or the powered state changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; low forces idle |
| fault_in | input | N_FAULT | Protection fault flags; any set bit forces fault |
| at_mode | input | 1 | 1 selects dual class events, 0 selects a single class event |
| legacy_en | input | 1 | Accept capacitive legacy signatures |
| backoff_ticks | input | BO_W | Retry delay after a failed detection, in clock ticks |
| meas_valid | input | 1 | One-cycle strobe: current probe, class or mark step is complete |
| meas_res | input | RES_W | Signature resistance in 100 Ω units, judged at the last probe level |
| meas_cap | input | CAP_W | Capacitive signature magnitude, judged at the last probe level |
| meas_class | input | CLASS_W | Class result of the completing class event |
| probe_req | output | 1 | Detection probe voltage requested |
| probe_lvl | output | PROBE_W | Probe level code 0..N_PROBE-1 |
| class_req | output | 1 | Class event voltage requested |
| mark_req | output | 1 | Mark event voltage requested |
| gate_en | output | 1 | Port switch enable |
| ilim_sel | output | 2 | Current limit: 0 off, 1 inrush, 2 single-event run, 3 dual-event run |
| status | output | 3 | 0 idle, 1 detecting, 2 classifying, 3 starting, 4 powered, 5 fault |
| class_out | output | CLASS_W | Last captured class value |

## Verification
The bench pushes the resistance judgment to both edges of the window and one unit past each. A design with an off-by-one compare would power a 189 load or reject a 265 one. It counts the idle cycles of back-off exactly, so a counter that loads one less or one more than asked shifts the restart by a cycle. It also fires stray completion strobes into back-off and the powered state, which would shorten back-off or disturb the captured class if they were not ignored. Dual-event runs check that the mark step sits between the two class events and that the second class value wins. Faults and disables in mid-detection and in the powered state check that the switch opens on the next clock and that detection then restarts at level 0 rather than resuming.

// File: rtl/poe_seq_pkg.sv
package poe_seq_pkg;

  typedef enum logic [2:0] {
    PS_IDLE  = 3'd0,
    PS_DET   = 3'd1,
    PS_CLS   = 3'd2,
    PS_START = 3'd3,
    PS_POWER = 3'd4,
    PS_FAULT = 3'd5
  } port_status_e;

  typedef enum logic [1:0] {
    IL_OFF    = 2'd0,
    IL_INRUSH = 2'd1,
    IL_RUN1   = 2'd2,
    IL_RUN2   = 2'd3
  } ilim_code_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DET,
    S_CLS1,
    S_MARK,
    S_CLS2,
    S_START,
    S_POWER,
    S_BACKOFF,
    S_FAULT
  } seq_state_e;

endpackage

// File: rtl/poe_seq_timer.sv
module poe_seq_timer #(
  parameter int TW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/poe_sig_judge.sv
module poe_sig_judge #(
  parameter int RES_W   = 10,
  parameter int RES_LO  = 190,
  parameter int RES_HI  = 265,
  parameter int CAP_W   = 8,
  parameter int CAP_MIN = 100
) (
  input  logic [RES_W-1:0] meas_res,
  input  logic [CAP_W-1:0] meas_cap,
  output logic             res_ok,
  output logic             cap_ok
);

  localparam logic [RES_W-1:0] LO_V  = RES_W'(RES_LO);
  localparam logic [RES_W-1:0] HI_V  = RES_W'(RES_HI);
  localparam logic [CAP_W-1:0] CAP_V = CAP_W'(CAP_MIN);

  always_comb begin
    res_ok = (meas_res >= LO_V) && (meas_res <= HI_V);
    cap_ok = (meas_cap >= CAP_V);
  end

endmodule

// File: rtl/poe_class_hold.sv
module poe_class_hold #(
  parameter int CLASS_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               cap,
  input  logic [CLASS_W-1:0] din,
  output logic [CLASS_W-1:0] dout
);

  logic [CLASS_W-1:0] cls_q;
  logic [CLASS_W-1:0] cls_d;
  logic               cls_en;

  always_comb begin
    cls_en = clr | cap;
    cls_d  = clr ? '0 : din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q <= '0;
    end else if (cls_en) begin
      cls_q <= cls_d;
    end
  end

  assign dout = cls_q;

endmodule

// File: rtl/poe_seq_fsm.sv
module poe_seq_fsm
  import poe_seq_pkg::*;
#(
  parameter int N_PROBE      = 4,
  parameter int PROBE_W      = 2,
  parameter int N_FAULT      = 3,
  parameter int TW           = 20,
  parameter int BO_W         = 16,
  parameter int INRUSH_TICKS = 520000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               port_en,
  input  logic [N_FAULT-1:0] fault_in,
  input  logic               at_mode,
  input  logic               legacy_en,
  input  logic [BO_W-1:0]    backoff_ticks,
  input  logic               meas_valid,
  input  logic               res_ok,
  input  logic               cap_ok,
  input  logic               tmr_zero,
  output logic               tmr_load,
  output logic [TW-1:0]      tmr_val,
  output logic               tmr_dec,
  output logic               cls_clr,
  output logic               cls_cap,
  output logic               probe_req,
  output logic [PROBE_W-1:0] probe_lvl,
  output logic               class_req,
  output logic               mark_req,
  output logic               gate_en,
  output logic [1:0]         ilim_sel,
  output logic [2:0]         status
);

  localparam logic [PROBE_W-1:0] LAST_STEP  = PROBE_W'(N_PROBE - 1);
  localparam logic [TW-1:0]      INRUSH_VAL = TW'(INRUSH_TICKS - 1);

  seq_state_e         state_q, state_d;
  logic [PROBE_W-1:0] step_q, step_d;
  logic               mode_q, mode_d;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    mode_d   = mode_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_dec  = 1'b0;
    cls_clr  = 1'b0;
    cls_cap  = 1'b0;
    if (|fault_in) begin
      state_d = S_FAULT;
    end else if (!port_en) begin
      state_d = S_IDLE;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          state_d = S_DET;
          step_d  = '0;
          mode_d  = at_mode;
          cls_clr = 1'b1;
        end
        S_DET: begin
          if (meas_valid) begin
            if (step_q != LAST_STEP) begin
              step_d = step_q + 1'b1;
            end else if (res_ok) begin
              state_d = S_CLS1;
            end else if (legacy_en && cap_ok) begin
              state_d  = S_START;
              tmr_load = 1'b1;
              tmr_val  = INRUSH_VAL;
            end else begin
              state_d  = S_BACKOFF;
              tmr_load = 1'b1;
              tmr_val  = TW'(backoff_ticks);
            end
          end
        end
        S_CLS1: begin
          if (meas_valid) begin
            cls_cap = 1'b1;
            if (mode_q) begin
              state_d = S_MARK;
            end else begin
              state_d  = S_START;
              tmr_load = 1'b1;
              tmr_val  = INRUSH_VAL;
            end
          end
        end
        S_MARK: begin
          if (meas_valid) begin
            state_d = S_CLS2;
          end
        end
        S_CLS2: begin
          if (meas_valid) begin
            cls_cap  = 1'b1;
            state_d  = S_START;
            tmr_load = 1'b1;
            tmr_val  = INRUSH_VAL;
          end
        end
        S_START: begin
          if (tmr_zero) begin
            state_d = S_POWER;
          end else begin
            tmr_dec = 1'b1;
          end
        end
        S_POWER: begin
          state_d = S_POWER;
        end
        S_BACKOFF: begin
          if (tmr_zero) begin
            state_d = S_IDLE;
          end else begin
            tmr_dec = 1'b1;
          end
        end
        S_FAULT: begin
          state_d = S_IDLE;
        end
        default: begin
          state_d = S_IDLE;
        end
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      mode_q  <= mode_d;
    end
  end

  // output decode
  always_comb begin
    probe_req = (state_q == S_DET);
    probe_lvl = (state_q == S_DET) ? step_q : '0;
    class_req = (state_q == S_CLS1) || (state_q == S_CLS2);
    mark_req  = (state_q == S_MARK);
    gate_en   = (state_q == S_START) || (state_q == S_POWER);
    ilim_sel  = IL_OFF;
    status    = PS_IDLE;
    unique case (state_q)
      S_DET:   status = PS_DET;
      S_CLS1,
      S_MARK,
      S_CLS2:  status = PS_CLS;
      S_START: begin
        status   = PS_START;
        ilim_sel = IL_INRUSH;
      end
      S_POWER: begin
        status   = PS_POWER;
        ilim_sel = mode_q ? IL_RUN2 : IL_RUN1;
      end
      S_FAULT: status = PS_FAULT;
      default: status = PS_IDLE;
    endcase
  end

endmodule

// File: rtl/poe_port_seq.sv
module poe_port_seq
  import poe_seq_pkg::*;
#(
  parameter int N_PROBE      = 4,
  parameter int N_FAULT      = 3,
  parameter int RES_W        = 10,
  parameter int RES_LO       = 190,
  parameter int RES_HI       = 265,
  parameter int CAP_W        = 8,
  parameter int CAP_MIN      = 100,
  parameter int CLASS_W      = 3,
  parameter int BO_W         = 16,
  parameter int INRUSH_TICKS = 520000,
  parameter int PROBE_W      = $clog2(N_PROBE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               port_en,
  input  logic [N_FAULT-1:0] fault_in,
  input  logic               at_mode,
  input  logic               legacy_en,
  input  logic [BO_W-1:0]    backoff_ticks,
  input  logic               meas_valid,
  input  logic [RES_W-1:0]   meas_res,
  input  logic [CAP_W-1:0]   meas_cap,
  input  logic [CLASS_W-1:0] meas_class,
  output logic               probe_req,
  output logic [PROBE_W-1:0] probe_lvl,
  output logic               class_req,
  output logic               mark_req,
  output logic               gate_en,
  output logic [1:0]         ilim_sel,
  output logic [2:0]         status,
  output logic [CLASS_W-1:0] class_out
);

  localparam int INR_W = $clog2(INRUSH_TICKS + 1);
  localparam int TW    = (INR_W > BO_W) ? INR_W : BO_W;

  logic          res_ok;
  logic          cap_ok;
  logic          tmr_zero;
  logic          tmr_load;
  logic          tmr_dec;
  logic [TW-1:0] tmr_val;
  logic          cls_clr;
  logic          cls_cap;

  poe_sig_judge #(
    .RES_W  (RES_W),
    .RES_LO (RES_LO),
    .RES_HI (RES_HI),
    .CAP_W  (CAP_W),
    .CAP_MIN(CAP_MIN)
  ) u_judge (
    .meas_res(meas_res),
    .meas_cap(meas_cap),
    .res_ok  (res_ok),
    .cap_ok  (cap_ok)
  );

  poe_seq_timer #(
    .TW(TW)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .dec     (tmr_dec),
    .zero    (tmr_zero)
  );

  poe_class_hold #(
    .CLASS_W(CLASS_W)
  ) u_class (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cls_clr),
    .cap  (cls_cap),
    .din  (meas_class),
    .dout (class_out)
  );

  poe_seq_fsm #(
    .N_PROBE     (N_PROBE),
    .PROBE_W     (PROBE_W),
    .N_FAULT     (N_FAULT),
    .TW          (TW),
    .BO_W        (BO_W),
    .INRUSH_TICKS(INRUSH_TICKS)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_en      (port_en),
    .fault_in     (fault_in),
    .at_mode      (at_mode),
    .legacy_en    (legacy_en),
    .backoff_ticks(backoff_ticks),
    .meas_valid   (meas_valid),
    .res_ok       (res_ok),
    .cap_ok       (cap_ok),
    .tmr_zero     (tmr_zero),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .tmr_dec      (tmr_dec),
    .cls_clr      (cls_clr),
    .cls_cap      (cls_cap),
    .probe_req    (probe_req),
    .probe_lvl    (probe_lvl),
    .class_req    (class_req),
    .mark_req     (mark_req),
    .gate_en      (gate_en),
    .ilim_sel     (ilim_sel),
    .status       (status)
  );

endmodule

// File: rtl/poe_port_seq_chk.sv
module poe_port_seq_chk #(
  parameter int N_FAULT = 3,
  parameter int PROBE_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               port_en,
  input logic [N_FAULT-1:0] fault_in,
  input logic               probe_req,
  input logic [PROBE_W-1:0] probe_lvl,
  input logic               class_req,
  input logic               mark_req,
  input logic               gate_en,
  input logic [1:0]         ilim_sel,
  input logic [2:0]         status
);

  // R9
  fault_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_in != '0) |=> (!gate_en && status == 3'd5));

  // R10
  disable_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && fault_in == '0) |=> (status == 3'd0 && !gate_en));

  // R4
  class_after_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd2 && $past(status) != 3'd2) |-> ($past(status) == 3'd1));

  // R4
  single_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({probe_req, class_req, mark_req}));

  // R2
  probe_step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_req && $past(probe_req) && probe_lvl != $past(probe_lvl))
      |-> (probe_lvl == $past(probe_lvl) + 1'b1));

  // R6
  power_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd4) |-> ($past(status) == 3'd3 || $past(status) == 3'd4));

  // R6
  gate_has_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en |-> (ilim_sel != 2'd0));

endmodule

bind poe_port_seq poe_port_seq_chk #(
  .N_FAULT(N_FAULT),
  .PROBE_W(PROBE_W)
) u_chk (.*);

// File: tb/poe_port_seq_bench.sv
`timescale 1ns/1ps
module poe_port_seq_bench;

  localparam int N_FAULT = 3;
  localparam int RES_W   = 10;
  localparam int CAP_W   = 8;
  localparam int CLASS_W = 3;
  localparam int BO_W    = 8;
  localparam int INRUSH  = 20;
  localparam int RLO     = 190;
  localparam int RHI     = 265;
  localparam int CMIN    = 100;

  localparam int M_IDLE = 0, M_DET = 1, M_C1 = 2, M_MK = 3, M_C2 = 4;
  localparam int M_ST = 5, M_PW = 6, M_BO = 7, M_FL = 8;

  logic               clk;
  logic               rst_n;
  logic               port_en;
  logic [N_FAULT-1:0] fault_in;
  logic               at_mode;
  logic               legacy_en;
  logic [BO_W-1:0]    backoff_ticks;
  logic               meas_valid;
  logic [RES_W-1:0]   meas_res;
  logic [CAP_W-1:0]   meas_cap;
  logic [CLASS_W-1:0] meas_class;
  logic               probe_req;
  logic [1:0]         probe_lvl;
  logic               class_req;
  logic               mark_req;
  logic               gate_en;
  logic [1:0]         ilim_sel;
  logic [2:0]         status;
  logic [CLASS_W-1:0] class_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int ms = M_IDLE, mstep = 0, mcnt = 0, mmode = 0, mcls = 0;

  poe_port_seq #(
    .N_FAULT(N_FAULT), .RES_W(RES_W), .RES_LO(RLO), .RES_HI(RHI),
    .CAP_W(CAP_W), .CAP_MIN(CMIN), .CLASS_W(CLASS_W), .BO_W(BO_W),
    .INRUSH_TICKS(INRUSH)
  ) u_poe_port_seq (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .fault_in(fault_in),
    .at_mode(at_mode), .legacy_en(legacy_en), .backoff_ticks(backoff_ticks),
    .meas_valid(meas_valid), .meas_res(meas_res), .meas_cap(meas_cap),
    .meas_class(meas_class), .probe_req(probe_req), .probe_lvl(probe_lvl),
    .class_req(class_req), .mark_req(mark_req), .gate_en(gate_en),
    .ilim_sel(ilim_sel), .status(status), .class_out(class_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = M_IDLE; mstep = 0; mcnt = 0; mmode = 0; mcls = 0;
    end else if (fault_in != 0) begin
      ms = M_FL;
    end else if (!port_en) begin
      ms = M_IDLE;
    end else begin
      case (ms)
        M_IDLE: begin ms = M_DET; mstep = 0; mmode = int'(at_mode); mcls = 0; end
        M_DET: if (meas_valid) begin
          if (mstep < 3) mstep = mstep + 1;
          else if (int'(meas_res) >= RLO && int'(meas_res) <= RHI) ms = M_C1;
          else if (legacy_en && int'(meas_cap) >= CMIN) begin ms = M_ST; mcnt = INRUSH - 1; end
          else begin ms = M_BO; mcnt = int'(backoff_ticks); end
        end
        M_C1: if (meas_valid) begin
          mcls = int'(meas_class);
          if (mmode != 0) ms = M_MK;
          else begin ms = M_ST; mcnt = INRUSH - 1; end
        end
        M_MK: if (meas_valid) ms = M_C2;
        M_C2: if (meas_valid) begin mcls = int'(meas_class); ms = M_ST; mcnt = INRUSH - 1; end
        M_ST: if (mcnt == 0) ms = M_PW; else mcnt = mcnt - 1;
        M_PW: ms = M_PW;
        M_BO: if (mcnt == 0) ms = M_IDLE; else mcnt = mcnt - 1;
        default: ms = M_IDLE;
      endcase
    end
  end

  function automatic int exp_status(int s);
    case (s)
      M_DET: return 1;
      M_C1, M_MK, M_C2: return 2;
      M_ST: return 3;
      M_PW: return 4;
      M_FL: return 5;
      default: return 0;
    endcase
  endfunction

  // per-cycle comparison away from the edge, plus watchdog
  always @(posedge clk) begin
    #3;
    cycles++;
    chk("R2", "probe_req", int'(probe_req), int'(ms == M_DET));
    chk("R2", "probe_lvl", int'(probe_lvl), (ms == M_DET) ? mstep : 0);
    chk("R4", "class_req", int'(class_req), int'(ms == M_C1 || ms == M_C2));
    chk("R4", "mark_req", int'(mark_req), int'(ms == M_MK));
    chk("R6", "gate_en", int'(gate_en), int'(ms == M_ST || ms == M_PW));
    chk("R6", "ilim_sel", int'(ilim_sel),
        (ms == M_ST) ? 1 : (ms == M_PW) ? ((mmode != 0) ? 3 : 2) : 0);
    chk("R9", "status", int'(status), exp_status(ms));
    chk("R5", "class_out", int'(class_out), mcls);
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic pulse(input int res, input int cap, input int cls);
    @(negedge clk);
    meas_valid = 1'b1;
    meas_res   = RES_W'(res);
    meas_cap   = CAP_W'(cap);
    meas_class = CLASS_W'(cls);
    @(negedge clk);
    meas_valid = 1'b0;
  endtask

  task automatic probe_three();
    for (int i = 1; i <= 3; i++) begin
      pulse(0, 0, 0);
      chk("R2", "probe_lvl step", int'(probe_lvl), i);
    end
  endtask

  initial begin
    rst_n = 1'b0; port_en = 1'b0; fault_in = '0; at_mode = 1'b0;
    legacy_en = 1'b0; backoff_ticks = BO_W'(5); meas_valid = 1'b0;
    meas_res = '0; meas_cap = '0; meas_class = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset status", int'(status), 0);
    chk("R1", "reset gate", int'(gate_en), 0);
    chk("R1", "reset ilim", int'(ilim_sel), 0);
    chk("R1", "reset class", int'(class_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset", int'(status), 0);

    // single-event pass
    port_en = 1'b1;
    @(negedge clk);
    chk("R10", "enable starts detection", int'(status), 1);
    chk("R2", "first level", int'(probe_lvl), 0);
    probe_three();
    pulse(220, 0, 0);
    chk("R3", "in-window passes", int'(status), 2);
    chk("R4", "class request", int'(class_req), 1);
    pulse(0, 0, 3);
    chk("R4", "single event then start", int'(status), 3);
    chk("R6", "inrush limit", int'(ilim_sel), 1);
    chk("R6", "gate closed", int'(gate_en), 1);
    repeat (INRUSH - 1) @(negedge clk);
    chk("R6", "still starting", int'(status), 3);
    @(negedge clk);
    chk("R6", "powered", int'(status), 4);
    chk("R6", "single-event run limit", int'(ilim_sel), 2);
    chk("R5", "class captured", int'(class_out), 3);
    pulse(100, 0, 6);
    chk("R11", "strobe in power ignored", int'(status), 4);
    chk("R11", "class unchanged in power", int'(class_out), 3);
    port_en = 1'b0;
    @(negedge clk);
    chk("R10", "disable idle", int'(status), 0);
    chk("R10", "disable gate off", int'(gate_en), 0);
    chk("R5", "class held when disabled", int'(class_out), 3);
    repeat (3) @(negedge clk);
    chk("R10", "stays idle", int'(status), 0);

    // dual-event pass, low window edge
    at_mode = 1'b1; port_en = 1'b1;
    @(negedge clk);
    chk("R5", "class cleared at detection", int'(class_out), 0);
    probe_three();
    pulse(RLO, 0, 0);
    chk("R3", "low edge passes", int'(status), 2);
    pulse(0, 0, 2);
    chk("R4", "mark after first class", int'(mark_req), 1);
    chk("R5", "first class value", int'(class_out), 2);
    pulse(0, 0, 0);
    chk("R4", "second class event", int'(class_req), 1);
    pulse(0, 0, 4);
    chk("R4", "start after two events", int'(status), 3);
    chk("R5", "second class value", int'(class_out), 4);
    repeat (INRUSH) @(negedge clk);
    chk("R6", "dual-event run limit", int'(ilim_sel), 3);

    // fault in power
    fault_in = 3'b100;
    @(negedge clk);
    chk("R9", "fault status", int'(status), 5);
    chk("R9", "fault gate off", int'(gate_en), 0);
    repeat (3) @(negedge clk);
    chk("R9", "fault held", int'(status), 5);
    fault_in = '0;
    @(negedge clk);
    chk("R9", "idle after fault", int'(status), 0);
    @(negedge clk);
    chk("R2", "restart detection", int'(status), 1);

    // high edge fail, legacy off, back-off timing
    at_mode = 1'b0;
    probe_three();
    pulse(RHI + 1, 200, 0);
    chk("R3", "above window fails", int'(status), 0);
    meas_valid = 1'b1;
    @(negedge clk);
    meas_valid = 1'b0;
    chk("R11", "strobe in backoff ignored", int'(status), 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R8", "backoff idle", int'(status), 0);
    end
    @(negedge clk);
    chk("R8", "retry after backoff", int'(status), 1);

    // legacy accept at capacity threshold
    legacy_en = 1'b1;
    probe_three();
    pulse(RLO - 1, CMIN, 5);
    chk("R7", "legacy start", int'(status), 3);
    chk("R7", "legacy class zero", int'(class_out), 0);
    repeat (INRUSH) @(negedge clk);
    chk("R7", "legacy powered", int'(status), 4);
    port_en = 1'b0;
    @(negedge clk);
    port_en = 1'b1;
    @(negedge clk);
    probe_three();
    pulse(300, CMIN - 1, 0);
    chk("R7", "small cap rejected", int'(status), 0);
    repeat (7) @(negedge clk);
    chk("R8", "retry detection", int'(status), 1);

    // high edge passes with legacy on; fault mid-detection
    pulse(0, 0, 0);
    pulse(0, 0, 0);
    fault_in = 3'b001;
    @(negedge clk);
    chk("R9", "fault in detection", int'(status), 5);
    chk("R9", "no probe in fault", int'(probe_req), 0);
    fault_in = '0;
    repeat (2) @(negedge clk);
    chk("R2", "restart at level 0", int'(probe_lvl), 0);
    probe_three();
    pulse(RHI, 0, 1);
    chk("R3", "high edge passes", int'(status), 2);
    pulse(0, 0, 1);
    chk("R5", "class after legacy-on pass", int'(class_out), 1);
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule